// File: doc/BRIEF.md
# Dual-Width Integer Execution Unit with Byte Reordering

This unit is the integer datapath of a 64-bit register machine. Each accepted request carries a 4-bit operation code, a source-select bit, a mode bit choosing 32-bit or 64-bit operation, a 16-bit modifier field, a 32-bit immediate, and the current values of the destination and source registers. One clock later the unit returns the new destination value together with a flag marking encodings it does not accept.

The unit covers addition, subtraction, multiplication, the bitwise operations, plain and sign-extending moves, negation, three kinds of shift, and byte-order conversion. Division and remainder, register storage, instruction fetch and memory access are all handled by other blocks. In 32-bit mode the arithmetic works on the low halves and clears the upper half of the result. The byte-order operation takes its width from the immediate. The host is little-endian by default, and a parameter selects a big-endian host instead.

Top module: `int_exec_unit`

## Requirements
- R1: After a synchronous active-low reset, `res_valid`, `res_value` and `res_illegal` are 0. `res_valid` equals the `in_valid` of the previous cycle.
- R2: When `use_reg` is 0 the source operand is `imm_field` sign-extended to 64 bits. When `use_reg` is 1 the source operand is `src_in`.
- R3: Operation codes: add 0x0, subtract 0x1, multiply 0x2, or 0x4, and 0x5, shift left 0x6, logical shift right 0x7, negate 0x8, xor 0xa, move 0xb, arithmetic shift right 0xc, byte reorder 0xd. With `wide_mode`=0, every accepted operation other than 0xd is computed on bits 31:0 and bits 63:32 of the result are 0.
- R4: With `wide_mode`=1, every accepted operation keeps the full 64-bit result, wrapping modulo 2^64.
- R5: The shift count is the source operand ANDed with 0x3F in 64-bit mode and with 0x1F in 32-bit mode. The arithmetic right shift fills vacated bits with the operand's top bit (bit 63 or bit 31).
- R6: A move with `ofs_field` equal to 8, 16 or 32 sign-extends that many low bits of `src_in`. This form requires `use_reg`=1. In 32-bit mode only 8 and 16 are accepted, and the result is then zero-extended from bit 31.
- R7: Negate returns the two's complement of `dst_in`. It requires `use_reg`=0.
- R8: For byte reorder in 32-bit mode, `imm_field` must be 16, 32 or 64 and gives the width. With `use_reg`=0 (to little-endian) the low width bits are kept. With `use_reg`=1 (to big-endian) the bytes of that width are reversed. In both cases all bits above the width are 0, and the result is not narrowed by the mode.
- R9: For byte reorder in 64-bit mode, the bytes of the selected width are always reversed and all bits above the width are 0. This form requires `use_reg`=0.
- R10: The unit flags an encoding as illegal for any of these cases: an opcode not listed in R3, a nonzero `ofs_field` on any operation other than move, a move offset other than 0/8/16/32, a rejected combination named in R6, R7 or R9, or a byte-reorder width other than 16/32/64. For an illegal encoding `res_illegal` is 1 and `res_value` equals `dst_in`.
- R11: In a cycle with `in_valid` low, `res_value` and `res_illegal` keep their previous values, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_code | input | 4 | Operation selector |
| use_reg | input | 1 | 1: register source; 0: immediate source (for byte reorder: target order) |
| wide_mode | input | 1 | 1: 64-bit mode; 0: 32-bit mode |
| ofs_field | input | 16 | Modifier field (sign-extend width for move) |
| imm_field | input | 32 | Immediate operand or byte-reorder width |
| dst_in | input | 64 | Current destination register value |
| src_in | input | 64 | Current source register value |
| res_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| res_value | output | 64 | New destination value |
| res_illegal | output | 1 | Encoding rejected; `res_value` holds `dst_in` |

## Verification
The unit has no state other than its output register, so a wrong internal decision appears at the ports on the cycle right after the request. Such a fault shows up as a wrong value, a stray illegal flag, or nonzero upper bits in 32-bit mode. Idle cycles are driven with random inputs, so any leak of those inputs into the output register changes `res_value` at the next sample. A behavioural model compares the ports on every clock, and the fault-prone choices get directed vectors: shift counts at and beyond the mask, sign-extension widths, every byte-reorder width and direction in both modes, and each rejected combination.

// File: rtl/exu_pkg.sv
// Package: shared opcode encodings of the integer execution unit.
// Assumes a 4-bit operation code; unlisted codes are rejected by the top.
package exu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_SHL  = 4'h6,
        OP_SHR  = 4'h7,
        OP_NEG  = 4'h8,
        OP_XOR  = 4'ha,
        OP_MOV  = 4'hb,
        OP_SAR  = 4'hc,
        OP_SWAP = 4'hd
    } exu_op_e;

    // Sign-extend widths the move operation accepts, in bits.
    localparam int SX_NARROW = 8;
    localparam int SX_MID    = 16;
    localparam int SX_WIDE   = 32;

endpackage

// File: rtl/exu_operand_sel.sv
// Module: picks the second operand of the unit.
// The immediate is sign-extended to the datapath width. The 32-bit mode
// only uses the low half, so one extension serves both modes.
module exu_operand_sel #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic              use_reg,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic [DATA_W-1:0] src_in,
    output logic [DATA_W-1:0] src_op
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    // Widen the immediate with copies of its sign bit.
    assign imm_ext = {{EXT_W{imm_field[IMM_W-1]}}, imm_field};

    // Register operand when selected, else the widened immediate.
    assign src_op = use_reg ? src_in : imm_ext;

endmodule

// File: rtl/exu_alu_core.sv
// Module: arithmetic, logic and shift results for both operand widths.
// Assumes DATA_W is a power of two. Shift counts are masked to the
// width's log2. The half-width result is zero-extended into the output.
module exu_alu_core
    import exu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [3:0]        op_code,
    input  logic              wide_mode,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] result
);
    localparam int HALF_W = DATA_W / 2;
    localparam int SH_F   = $clog2(DATA_W);
    localparam int SH_H   = $clog2(HALF_W);

    logic [DATA_W-1:0] full_r;
    logic [HALF_W-1:0] half_r;
    logic [HALF_W-1:0] a_h;
    logic [HALF_W-1:0] b_h;
    logic [SH_F-1:0]   sh_f;
    logic [SH_H-1:0]   sh_h;

    assign a_h  = a_in[HALF_W-1:0];
    assign b_h  = b_in[HALF_W-1:0];
    assign sh_f = b_in[SH_F-1:0];
    assign sh_h = b_in[SH_H-1:0];

    // Full-width result for the wide mode.
    always_comb begin
        case (op_code)
            OP_ADD:  full_r = a_in + b_in;
            OP_SUB:  full_r = a_in - b_in;
            OP_MUL:  full_r = a_in * b_in;
            OP_OR:   full_r = a_in | b_in;
            OP_AND:  full_r = a_in & b_in;
            OP_XOR:  full_r = a_in ^ b_in;
            OP_SHL:  full_r = a_in << sh_f;
            OP_SHR:  full_r = a_in >> sh_f;
            OP_SAR:  full_r = $signed(a_in) >>> sh_f;
            OP_NEG:  full_r = -a_in;
            OP_MOV:  full_r = b_in;
            default: full_r = a_in;
        endcase
    end

    // Half-width result for the narrow mode.
    always_comb begin
        case (op_code)
            OP_ADD:  half_r = a_h + b_h;
            OP_SUB:  half_r = a_h - b_h;
            OP_MUL:  half_r = a_h * b_h;
            OP_OR:   half_r = a_h | b_h;
            OP_AND:  half_r = a_h & b_h;
            OP_XOR:  half_r = a_h ^ b_h;
            OP_SHL:  half_r = a_h << sh_h;
            OP_SHR:  half_r = a_h >> sh_h;
            OP_SAR:  half_r = $signed(a_h) >>> sh_h;
            OP_NEG:  half_r = -a_h;
            OP_MOV:  half_r = b_h;
            default: half_r = a_h;
        endcase
    end

    // Mode select, with the upper half cleared in narrow mode.
    assign result = wide_mode ? full_r : {{(DATA_W - HALF_W){1'b0}}, half_r};

endmodule

// File: rtl/exu_movsx.sv
// Module: sign-extending move.
// Extends the low 8, 16 or 32 bits of the source register to the full
// width. The narrow mode accepts only the two smaller widths and returns
// the low half zero-extended. ok is low for an unsupported width.
module exu_movsx
    import exu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int OFF_W  = 16
) (
    input  logic              wide_mode,
    input  logic [OFF_W-1:0]  ofs_field,
    input  logic [DATA_W/2-1:0] src_low,
    output logic [DATA_W-1:0] sx_val,
    output logic              sx_ok
);
    localparam int HALF_W = DATA_W / 2;
    localparam int N_EXT  = 3;

    logic [N_EXT-1:0][DATA_W-1:0] ext_v;
    logic [DATA_W-1:0]            pick;

    // One sign extension per supported width, 8 << k bits wide.
    for (genvar k = 0; k < N_EXT; k++) begin : g_ext
        localparam int W = SX_NARROW << k;
        assign ext_v[k] = {{(DATA_W - W){src_low[W-1]}}, src_low[W-1:0]};
    end

    // Decode the width field and choose the matching extension.
    always_comb begin
        pick  = '0;
        sx_ok = 1'b0;
        if (ofs_field == OFF_W'(SX_NARROW)) begin
            pick  = ext_v[0];
            sx_ok = 1'b1;
        end else if (ofs_field == OFF_W'(SX_MID)) begin
            pick  = ext_v[1];
            sx_ok = 1'b1;
        end else if (ofs_field == OFF_W'(SX_WIDE)) begin
            pick  = ext_v[2];
            sx_ok = wide_mode;
        end
    end

    // Narrow mode keeps only the low half.
    assign sx_val = wide_mode ? pick : {{(DATA_W - HALF_W){1'b0}}, pick[HALF_W-1:0]};

endmodule

// File: rtl/exu_byteswap.sv
// Module: byte-order conversion of the destination value.
// The immediate gives a width of 16 << k bits. The output holds either the
// low bytes of that width unchanged or the same bytes reversed, with zero
// above the width. LITTLE_HOST sets which target order needs the reversal.
// Wide mode always reverses.
module exu_byteswap #(
    parameter int DATA_W      = 64,
    parameter int IMM_W       = 32,
    parameter int LITTLE_HOST = 1
) (
    input  logic              wide_mode,
    input  logic              to_big,
    input  logic [IMM_W-1:0]  width_sel,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              sw_ok
);
    localparam int NB    = DATA_W / 8;
    localparam int NW    = $clog2(NB);
    localparam int IDX_W = (NW > 1) ? $clog2(NW) : 1;

    logic [NW-1:0][DATA_W-1:0] rev_v;
    logic [NW-1:0][DATA_W-1:0] keep_v;
    logic [IDX_W-1:0]          idx;
    logic                      hit;
    logic                      do_rev;

    // Reversed and unchanged copies of each width, zero above it.
    for (genvar k = 0; k < NW; k++) begin : g_w
        localparam int B = 2 << k;
        for (genvar i = 0; i < NB; i++) begin : g_b
            if (i < B) begin : g_in
                assign rev_v[k][8*i +: 8]  = din[8*(B-1-i) +: 8];
                assign keep_v[k][8*i +: 8] = din[8*i +: 8];
            end else begin : g_out
                assign rev_v[k][8*i +: 8]  = 8'h00;
                assign keep_v[k][8*i +: 8] = 8'h00;
            end
        end
    end

    // Host order decides which target order needs the reversal.
    if (LITTLE_HOST != 0) begin : g_le_host
        assign do_rev = wide_mode | to_big;
    end else begin : g_be_host
        assign do_rev = wide_mode | ~to_big;
    end

    // Map the width immediate to a width index.
    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int k = 0; k < NW; k++) begin
            if (width_sel == IMM_W'(16 << k)) begin
                idx = IDX_W'(k);
                hit = 1'b1;
            end
        end
    end

    // Final selection; an unknown width passes the input through.
    always_comb begin
        dout = din;
        if (hit) dout = do_rev ? rev_v[idx] : keep_v[idx];
    end

    // Wide mode reserves the direction bit, so it must be 0.
    assign sw_ok = hit & ~(wide_mode & to_big);

endmodule

// File: rtl/int_exec_unit.sv
// Module: top of the integer execution unit.
// Validates the encoding, selects the result of the matching sub-unit and
// registers result and illegal flag on the request strobe. Latency is one
// cycle. The output register holds between requests. A rejected request
// returns the destination value unchanged.
module int_exec_unit
    import exu_pkg::*;
#(
    parameter int DATA_W      = 64,
    parameter int IMM_W       = 32,
    parameter int OFF_W       = 16,
    parameter int LITTLE_HOST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op_code,
    input  logic              use_reg,
    input  logic              wide_mode,
    input  logic [OFF_W-1:0]  ofs_field,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic [DATA_W-1:0] dst_in,
    input  logic [DATA_W-1:0] src_in,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_value,
    output logic              res_illegal
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] src_op;
    logic [DATA_W-1:0] alu_val;
    logic [DATA_W-1:0] sx_val;
    logic [DATA_W-1:0] swap_val;
    logic [DATA_W-1:0] next_val;
    logic              sx_ok;
    logic              swap_ok;
    logic              ofs_zero;
    logic              legal;

    exu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .use_reg   (use_reg),
        .imm_field (imm_field),
        .src_in    (src_in),
        .src_op    (src_op)
    );

    exu_alu_core #(.DATA_W(DATA_W)) u_alu (
        .op_code   (op_code),
        .wide_mode (wide_mode),
        .a_in      (dst_in),
        .b_in      (src_op),
        .result    (alu_val)
    );

    exu_movsx #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_movsx (
        .wide_mode (wide_mode),
        .ofs_field (ofs_field),
        .src_low   (src_in[HALF_W-1:0]),
        .sx_val    (sx_val),
        .sx_ok     (sx_ok)
    );

    exu_byteswap #(.DATA_W(DATA_W), .IMM_W(IMM_W), .LITTLE_HOST(LITTLE_HOST)) u_swap (
        .wide_mode (wide_mode),
        .to_big    (use_reg),
        .width_sel (imm_field),
        .din       (dst_in),
        .dout      (swap_val),
        .sw_ok     (swap_ok)
    );

    assign ofs_zero = (ofs_field == '0);

    // Encoding check: opcode, modifier field and source-bit combinations.
    always_comb begin
        case (op_code)
            OP_ADD, OP_SUB, OP_MUL, OP_OR, OP_AND,
            OP_SHL, OP_SHR, OP_XOR, OP_SAR: legal = ofs_zero;
            OP_NEG:  legal = ofs_zero & ~use_reg;
            OP_MOV:  legal = ofs_zero | (use_reg & sx_ok);
            OP_SWAP: legal = ofs_zero & swap_ok;
            default: legal = 1'b0;
        endcase
    end

    // Result select; a rejected request returns the destination unchanged.
    always_comb begin
        if (!legal)
            next_val = dst_in;
        else if (op_code == OP_MOV && !ofs_zero)
            next_val = sx_val;
        else if (op_code == OP_SWAP)
            next_val = swap_val;
        else
            next_val = alu_val;
    end

    // Output register: strobe follows the request; data loads only on it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_value   <= '0;
            res_illegal <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                res_value   <= next_val;
                res_illegal <= ~legal;
            end
        end
    end

endmodule

// File: rtl/exu_exec_chk.sv
// Module: temporal checks on the execution unit's ports, bound to the top.
// Assumes the synchronous active-low reset of the unit.
module exu_exec_chk
    import exu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int OFF_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op_code,
    input logic              use_reg,
    input logic              wide_mode,
    input logic [OFF_W-1:0]  ofs_field,
    input logic [DATA_W-1:0] dst_in,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_value,
    input logic              res_illegal
);
    localparam int HALF_W = DATA_W / 2;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);

    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_value) && $stable(res_illegal)));

    // R3
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_mode && op_code != OP_SWAP)
        |=> (res_illegal || res_value[DATA_W-1:HALF_W] == '0));

    // R7
    neg_reg_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OP_NEG && use_reg)
        |=> (res_illegal && res_value == $past(dst_in)));

    // R6
    movsx_imm_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OP_MOV && ofs_field != '0 && !use_reg)
        |=> res_illegal);

    // R9
    swap_wide_dir_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OP_SWAP && wide_mode && use_reg)
        |=> res_illegal);

    // R10
    illegal_keeps_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_code == 4'h3 || op_code == 4'h9 || op_code == 4'he || op_code == 4'hf))
        |=> (res_illegal && res_value == $past(dst_in)));

endmodule

bind int_exec_unit exu_exec_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op_code     (op_code),
    .use_reg     (use_reg),
    .wide_mode   (wide_mode),
    .ofs_field   (ofs_field),
    .dst_in      (dst_in),
    .res_valid   (res_valid),
    .res_value   (res_value),
    .res_illegal (res_illegal)
);

// File: tb/int_exec_unit_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the ports every clock.
module int_exec_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  op_code;
    logic        use_reg;
    logic        wide_mode;
    logic [15:0] ofs_field;
    logic [31:0] imm_field;
    logic [63:0] dst_in;
    logic [63:0] src_in;
    logic        res_valid;
    logic [63:0] res_value;
    logic        res_illegal;

    int    n_cmp  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    logic        exp_valid = 1'b0;
    logic [63:0] exp_value = '0;
    logic        exp_ill   = 1'b0;
    string       exp_tag   = "R1";

    always #4 clk = ~clk;

    int_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .use_reg(use_reg), .wide_mode(wide_mode), .ofs_field(ofs_field),
        .imm_field(imm_field), .dst_in(dst_in), .src_in(src_in),
        .res_valid(res_valid), .res_value(res_value), .res_illegal(res_illegal)
    );

    // Reference model from the requirements.
    function automatic void model(input logic [3:0] op, input logic sel, input logic wide,
                                  input logic [15:0] off, input logic [31:0] im,
                                  input logic [63:0] d, input logic [63:0] s,
                                  output logic [63:0] r, output logic ill, output string tag);
        logic [63:0] b;
        logic [31:0] a32;
        logic [31:0] b32;
        longint      sx;
        int          nb;
        bit          rev;
        b   = sel ? s : {{32{im[31]}}, im};
        a32 = d[31:0];
        b32 = b[31:0];
        ill = 1'b0;
        r   = d;
        sx  = 0;
        tag = wide ? "R4" : "R3";
        if (off != 0 && op != 4'hb) ill = 1'b1;
        case (op)
            4'h0: r = wide ? d + b : {32'h0, a32 + b32};
            4'h1: r = wide ? d - b : {32'h0, a32 - b32};
            4'h2: r = wide ? d * b : {32'h0, a32 * b32};
            4'h4: r = wide ? (d | b) : {32'h0, a32 | b32};
            4'h5: r = wide ? (d & b) : {32'h0, a32 & b32};
            4'ha: r = wide ? (d ^ b) : {32'h0, a32 ^ b32};
            4'h6: begin tag = "R5"; r = wide ? d << b[5:0] : {32'h0, a32 << b32[4:0]}; end
            4'h7: begin tag = "R5"; r = wide ? d >> b[5:0] : {32'h0, a32 >> b32[4:0]}; end
            4'hc: begin
                tag = "R5";
                if (wide) r = $signed(d) >>> b[5:0];
                else      r = {32'h0, 32'($signed(a32) >>> b32[4:0])};
            end
            4'h8: begin
                tag = "R7";
                if (sel) ill = 1'b1;
                r = wide ? 64'd0 - d : {32'h0, 32'd0 - a32};
            end
            4'hb: begin
                if (off == 0) r = wide ? b : {32'h0, b32};
                else begin
                    tag = "R6";
                    if (!sel) ill = 1'b1;
                    if (off == 8) sx = longint'($signed(s[7:0]));
                    else if (off == 16) sx = longint'($signed(s[15:0]));
                    else if (off == 32 && wide) sx = longint'($signed(s[31:0]));
                    else ill = 1'b1;
                    r = wide ? 64'(sx) : {32'h0, 32'(sx)};
                end
            end
            4'hd: begin
                tag = wide ? "R9" : "R8";
                nb  = (im == 16) ? 2 : (im == 32) ? 4 : (im == 64) ? 8 : 0;
                if (nb == 0) ill = 1'b1;
                if (wide && sel) ill = 1'b1;
                rev = wide || sel;
                r = '0;
                for (int i = 0; i < nb; i++)
                    r[8*i +: 8] = rev ? d[8*(nb-1-i) +: 8] : d[8*i +: 8];
            end
            default: ill = 1'b1;
        endcase
        if (ill) begin
            r   = d;
            tag = "R10";
        end
    endfunction

    // Compare all outputs against the model state.
    task automatic check_now();
        n_cmp++;
        if (res_valid !== exp_valid) begin
            n_fail++;
            $display("FAIL R1 valid actual=%0b expected=%0b", res_valid, exp_valid);
        end else if (res_value !== exp_value || res_illegal !== exp_ill) begin
            n_fail++;
            $display("FAIL %s actual=%h/%0b expected=%h/%0b",
                     exp_tag, res_value, res_illegal, exp_value, exp_ill);
        end
    endtask

    // One clock: check the previous result, then drive and predict the next.
    task automatic step(input logic v, input logic [3:0] op, input logic sel, input logic wide,
                        input logic [15:0] off, input logic [31:0] im,
                        input logic [63:0] d, input logic [63:0] s, input string tg);
        logic [63:0] ev;
        logic        ei;
        string       mt;
        @(negedge clk);
        check_now();
        in_valid = v; op_code = op; use_reg = sel; wide_mode = wide;
        ofs_field = off; imm_field = im; dst_in = d; src_in = s;
        if (v) begin
            model(op, sel, wide, off, im, d, s, ev, ei, mt);
            exp_valid = 1'b1;
            exp_value = ev;
            exp_ill   = ei;
            exp_tag   = (tg != "") ? tg : mt;
        end else begin
            exp_valid = 1'b0;
            exp_tag   = (tg != "") ? tg : "R11";
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op_code = '0; use_reg = 1'b0; wide_mode = 1'b0;
        ofs_field = '0; imm_field = '0; dst_in = '0; src_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state is checked by the first step
        step(1'b0, 4'h0, 1'b0, 1'b0, 16'd0, 32'd0, 64'd0, 64'd0, "R1");
        // R2 negative immediate is sign-extended in 64-bit mode
        step(1'b1, 4'h0, 1'b0, 1'b1, 16'd0, 32'hFFFF_FFFF, 64'd5, 64'd99, "R2");
        step(1'b1, 4'h0, 1'b1, 1'b1, 16'd0, 32'hFFFF_FFFF, 64'd5, 64'd99, "R2");
        // R3 narrow add wraps and clears upper half
        step(1'b1, 4'h0, 1'b1, 1'b0, 16'd0, 32'd0, 64'hAAAA_AAAA_FFFF_FFFF, 64'd2, "R3");
        // R4 wide multiply keeps 64 bits
        step(1'b1, 4'h2, 1'b1, 1'b1, 16'd0, 32'd0, 64'h1_0000_0003, 64'h7_0000_0001, "R4");
        // R5 shift counts beyond the mask
        step(1'b1, 4'h6, 1'b1, 1'b1, 16'd0, 32'd0, 64'h1, 64'd65, "R5");
        step(1'b1, 4'h6, 1'b1, 1'b0, 16'd0, 32'd0, 64'h1, 64'd33, "R5");
        step(1'b1, 4'hc, 1'b0, 1'b0, 16'd0, 32'd4, 64'h0000_0000_8000_0000, 64'd0, "R5");
        step(1'b1, 4'hc, 1'b0, 1'b1, 16'd0, 32'd63, 64'h8000_0000_0000_0000, 64'd0, "R5");
        // R6 sign-extending moves
        step(1'b1, 4'hb, 1'b1, 1'b1, 16'd8, 32'd0, 64'd0, 64'h1234_5680, "R6");
        step(1'b1, 4'hb, 1'b1, 1'b0, 16'd16, 32'd0, 64'd0, 64'h0000_9abc, "R6");
        step(1'b1, 4'hb, 1'b1, 1'b1, 16'd32, 32'd0, 64'd0, 64'h0000_0000_8000_0001, "R6");
        // R7 negate
        step(1'b1, 4'h8, 1'b0, 1'b0, 16'd0, 32'd0, 64'hFFFF_0000_0000_0001, 64'd0, "R7");
        step(1'b1, 4'h8, 1'b0, 1'b1, 16'd0, 32'd0, 64'd1, 64'd0, "R7");
        // R8 narrow byte reorder: little keeps, big reverses
        step(1'b1, 4'hd, 1'b0, 1'b0, 16'd0, 32'd32, 64'h1122_3344_5566_7788, 64'd0, "R8");
        step(1'b1, 4'hd, 1'b1, 1'b0, 16'd16, 32'd16, 64'h1122_3344_5566_7788, 64'd0, "R10");
        step(1'b1, 4'hd, 1'b1, 1'b0, 16'd0, 32'd16, 64'h1122_3344_5566_7788, 64'd0, "R8");
        step(1'b1, 4'hd, 1'b1, 1'b0, 16'd0, 32'd64, 64'h1122_3344_5566_7788, 64'd0, "R8");
        // R9 wide byte reorder always reverses
        step(1'b1, 4'hd, 1'b0, 1'b1, 16'd0, 32'd32, 64'h1122_3344_5566_7788, 64'd0, "R9");
        step(1'b1, 4'hd, 1'b0, 1'b1, 16'd0, 32'd64, 64'h1122_3344_5566_7788, 64'd0, "R9");
        // R10 rejected encodings keep dst
        step(1'b1, 4'hd, 1'b1, 1'b1, 16'd0, 32'd64, 64'h1122_3344_5566_7788, 64'd0, "R10");
        step(1'b1, 4'h8, 1'b1, 1'b1, 16'd0, 32'd0, 64'h55, 64'd0, "R10");
        step(1'b1, 4'hb, 1'b0, 1'b1, 16'd8, 32'd0, 64'h66, 64'hFF, "R10");
        step(1'b1, 4'hb, 1'b1, 1'b0, 16'd32, 32'd0, 64'h77, 64'hFF, "R10");
        step(1'b1, 4'h3, 1'b1, 1'b1, 16'd0, 32'd0, 64'h88, 64'd3, "R10");
        step(1'b1, 4'h0, 1'b1, 1'b1, 16'd1, 32'd0, 64'h99, 64'd3, "R10");
        step(1'b1, 4'hd, 1'b0, 1'b0, 16'd0, 32'd8, 64'hAB, 64'd0, "R10");
        // R11 idle with changing inputs holds the result
        step(1'b0, 4'h0, 1'b1, 1'b1, 16'd0, 32'd0, 64'hDEAD, 64'hBEEF, "R11");
        step(1'b0, 4'h2, 1'b0, 1'b0, 16'd8, 32'd7, 64'h1234, 64'h5678, "R11");
        // Mixed random traffic
        for (int n = 0; n < 800; n++) begin
            logic [3:0]  rop;
            logic [15:0] roff;
            logic [31:0] rim;
            int          pick;
            rop  = 4'($urandom_range(0, 15));
            pick = $urandom_range(0, 7);
            roff = (pick == 1) ? 16'd8 : (pick == 2) ? 16'd16 : (pick == 3) ? 16'd32 :
                   (pick == 4) ? 16'($urandom) : 16'd0;
            pick = $urandom_range(0, 4);
            rim  = (rop != 4'hd) ? $urandom : (pick == 0) ? 32'd16 : (pick == 1) ? 32'd32 :
                   (pick == 2) ? 32'd64 : (pick == 3) ? 32'd48 : $urandom;
            step((n % 7) != 6, rop, 1'($urandom), 1'($urandom), roff, rim,
                 {$urandom, $urandom}, {$urandom, $urandom}, "");
        end
        @(negedge clk);
        check_now();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule